// File: doc/BRIEF.md
# Locked Read-Modify-Write Bus Sequencer

This block is a synchronous bus master that carries out one indivisible read-modify-write sequence on a 32-bit bus with separate strobes. It accepts a request made of a base address, an operand size and the number of read and write transfers. It runs the read transfers and returns each captured data word. It then leaves the bus quiet for a configurable number of idle clocks while an outside modify step works. Last, it runs the write transfers with the data that the modify step supplies. The bus stays locked from the first read clock to the end of the final write, so no other master can come in between.

Every transfer takes an address clock with a one-clock start strobe, then one or more data clocks that end when the target returns its acknowledge. A "last write" flag marks the final write transfer. When another locked request is waiting as the final write ends, the next sequence starts at once: the lock and the transfer-in-progress signal stay high.

All bus control outputs are active high in this block. Transfer `i` of either phase uses the address `base + 4*i`.

Top module: `rmw_lock_seq`

## Requirements
- R1: `req_ready` is high while no sequence is active. A request is accepted on a clock where `req_valid` and `req_ready` are both high. The next clock is the first read address clock, and `lock_o` is high from that clock on.
- R2: A read address clock drives `ts_o`=1, `tip_o`=1, `rw_o`=1 and `bus_addr`=base+4*i, and `ta_i` is ignored in that clock. In the following data clocks, a high `ta_i` captures `data_in`. The clock after that capture shows `rd_valid`=1 and the word on `rd_data`.
- R3: While `ta_i` is low in a data clock, a wait state follows: the block stays in the data clock with `ts_o`=0 and `tip_o`=1, and it samples again on every edge.
- R4: In the clock after the acknowledge of the last read, `tip_o` is 0. Idle clocks follow, at least `IDLE_CLKS` of them and more until `mod_done` is high. In these clocks `ts_o`=0, `rw_o`=1, `lock_o`=1, `data_oe`=0, and `ta_i` is ignored.
- R5: A write address clock drives `ts_o`=1 for that single clock, `tip_o`=1, `rw_o`=0 and `bus_addr`=base+4*i. No data lane is enabled in this clock.
- R6: `locke_o` is high in every clock of the final write transfer and low in all earlier write transfers.
- R7: In write data clocks, `data_oe` enables lanes by `req_size` and by the two low address bits: 00 gives one byte, lane = addr[1:0]; 01 gives a halfword, lanes 3:2 when addr[1]=1 and lanes 1:0 otherwise; 10 and 11 give all four lanes. Lane k is `data_out[8k+7:8k]` and carries `wr_data[8k+7:8k]`.
- R8: In the clock after an acknowledged write data clock, `data_oe` is 0.
- R9: When the final write is acknowledged, `done_o` pulses in the next clock. If no request follows, that next clock also has `lock_o`, `locke_o` and `tip_o` at 0 and `rw_o` at 1.
- R10: When `req_valid` is high during the acknowledged clock of the final write, the request is accepted in that clock. The next clock is a read address clock with `lock_o` and `tip_o` still high.
- R11: While `rst_n` is low, the block is reset at each clock edge. After reset all strobes are inactive, `rw_o`=1 and `data_oe`=0, even if reset arrives in the middle of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | ADDR_W | Base address of the operand |
| req_size | input | 2 | Operand size code |
| req_rd_cnt | input | CNT_W | Number of read transfers (at least 1) |
| req_wr_cnt | input | CNT_W | Number of write transfers (at least 1) |
| mod_done | input | 1 | Modify step has finished |
| wr_data | input | 32 | Data for the current write transfer |
| rd_data | output | 32 | Last captured read word |
| rd_valid | output | 1 | `rd_data` updated this clock |
| done_o | output | 1 | Sequence completed pulse |
| bus_addr | output | ADDR_W | Transfer address |
| bus_size | output | 2 | Transfer size code |
| ts_o | output | 1 | Transfer start strobe |
| tip_o | output | 1 | Transfer in progress |
| rw_o | output | 1 | 1 = read, 0 = write |
| lock_o | output | 1 | Bus locked for the sequence |
| locke_o | output | 1 | Final write transfer of the lock |
| ta_i | input | 1 | Transfer acknowledge from target |
| data_in | input | 32 | Read data from the bus |
| data_out | output | 32 | Write data to the bus |
| data_oe | output | 4 | Per-lane output enable |

## Verification
Requests with one to three reads and one to three writes are mixed with random wait-state counts. Runs with a single write show `locke_o` on the only transfer, and runs with several writes show that it stays low until the final one. The bench drives `mod_done` both early and late, which separates the fixed idle minimum from waiting on the modify step. A high acknowledge in address and idle clocks shows whether the block wrongly samples it there. Runs that chain into a second request are set against runs that end, and reset is applied once in the middle of a sequence; together these show whether the lock and transfer-in-progress signals are held or released as they should be.

// File: rtl/rmw_seq_pkg.sv
// Shared types for the locked read-modify-write sequencer.
// Assumes a 32-bit data bus made of four byte lanes.
package rmw_seq_pkg;
    localparam int LANES  = 4;
    localparam int DATA_W = 8 * LANES;

    typedef enum logic [2:0] {
        PH_FREE,   // no sequence active
        PH_RADDR,  // read address clock
        PH_RDATA,  // read data / wait clocks
        PH_GAP,    // idle clocks while the modify step runs
        PH_WADDR,  // write address clock
        PH_WDATA   // write data / wait clocks
    } phase_t;

    // Lane enables from the size code and the low address bits (aligned operands)
    function automatic logic [LANES-1:0] lane_mask(input logic [1:0] sz, input logic [1:0] a);
        case (sz)
            2'b00:   return 4'b0001 << a;
            2'b01:   return a[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction
endpackage

// File: rtl/rmw_lane_dec.sv
// Byte-lane decoder: enables the lanes a write transfer uses and gates the
// write word onto them. Assumes operands are aligned to their size.
module rmw_lane_dec
    import rmw_seq_pkg::*;
(
    input  logic [1:0]        size,
    input  logic [1:0]        a_lo,
    input  logic              drive,
    input  logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  oe,
    output logic [DATA_W-1:0] dout
);
    // Lane enables are only active in a write data clock
    always_comb begin
        oe = drive ? lane_mask(size, a_lo) : '0;
    end

    // One gate per lane: an unselected lane outputs zero
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign dout[8*k +: 8] = oe[k] ? wdata[8*k +: 8] : 8'h00;
    end
endmodule

// File: rtl/rmw_phase_fsm.sv
// Phase controller: keeps the transfer counters, the idle-clock count and the
// request handshake. Assumes both transfer counts are at least 1 and
// IDLE_CLKS is at least 1.
module rmw_phase_fsm
    import rmw_seq_pkg::*;
#(
    parameter int CNT_W     = 3,
    parameter int IDLE_CLKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [CNT_W-1:0] req_rd_cnt,
    input  logic [CNT_W-1:0] req_wr_cnt,
    input  logic             ta_i,
    input  logic             mod_done,
    output phase_t           phase,
    output logic             req_ready,
    output logic             accept,
    output logic             last_wr,
    output logic             rd_hit,
    output logic             seq_end,
    output logic [CNT_W-1:0] xfer_idx
);
    localparam int IW = (IDLE_CLKS > 1) ? $clog2(IDLE_CLKS) : 1;
    localparam logic [IW-1:0] GAP_LAST = IW'(IDLE_CLKS - 1);

    logic [CNT_W-1:0] rd_left, wr_left;
    logic [IW-1:0]    gap_cnt;
    logic             wr_hit, last_rd, gap_ok;
    phase_t           phase_nx;

    // Acknowledge events and handshake terms
    always_comb begin
        rd_hit    = (phase == PH_RDATA) && ta_i;
        wr_hit    = (phase == PH_WDATA) && ta_i;
        last_rd   = (rd_left == CNT_W'(1));
        last_wr   = (wr_left == CNT_W'(1));
        seq_end   = wr_hit && last_wr;
        req_ready = (phase == PH_FREE) || seq_end;
        accept    = req_valid && req_ready;
        gap_ok    = (gap_cnt == GAP_LAST) && mod_done;
    end

    // Next phase
    always_comb begin
        phase_nx = phase;
        case (phase)
            PH_FREE:  if (accept) phase_nx = PH_RADDR;
            PH_RADDR: phase_nx = PH_RDATA;
            PH_RDATA: if (ta_i) phase_nx = last_rd ? PH_GAP : PH_RADDR;
            PH_GAP:   if (gap_ok) phase_nx = PH_WADDR;
            PH_WADDR: phase_nx = PH_WDATA;
            PH_WDATA: if (ta_i) begin
                if (!last_wr)    phase_nx = PH_WADDR;
                else if (accept) phase_nx = PH_RADDR;
                else             phase_nx = PH_FREE;
            end
            default:  phase_nx = PH_FREE;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_FREE;
        else        phase <= phase_nx;
    end

    // Transfer counters and transfer index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_left  <= '0;
            wr_left  <= '0;
            xfer_idx <= '0;
        end else if (accept) begin
            rd_left  <= req_rd_cnt;
            wr_left  <= req_wr_cnt;
            xfer_idx <= '0;
        end else if (rd_hit) begin
            rd_left  <= rd_left - CNT_W'(1);
            xfer_idx <= last_rd ? '0 : xfer_idx + CNT_W'(1);
        end else if (wr_hit) begin
            wr_left  <= wr_left - CNT_W'(1);
            xfer_idx <= xfer_idx + CNT_W'(1);
        end
    end

    // Idle-clock counter, saturating at the last required idle clock
    always_ff @(posedge clk) begin
        if (!rst_n || phase != PH_GAP) gap_cnt <= '0;
        else if (gap_cnt != GAP_LAST)  gap_cnt <= gap_cnt + IW'(1);
    end
endmodule

// File: rtl/rmw_lock_seq.sv
// Locked read-modify-write bus sequencer (top). Decodes the bus strobes from
// the phase, forms transfer addresses, captures read data and reports done.
// Assumes aligned operands and a target that acknowledges eventually.
module rmw_lock_seq
    import rmw_seq_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 3,
    parameter int IDLE_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [CNT_W-1:0]  req_rd_cnt,
    input  logic [CNT_W-1:0]  req_wr_cnt,
    input  logic              mod_done,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              done_o,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic              ts_o,
    output logic              tip_o,
    output logic              rw_o,
    output logic              lock_o,
    output logic              locke_o,
    input  logic              ta_i,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic [LANES-1:0]  data_oe
);
    phase_t            phase;
    logic              accept, last_wr, rd_hit, seq_end;
    logic [CNT_W-1:0]  xfer_idx;
    logic [ADDR_W-1:0] base_q;
    logic [1:0]        size_q;

    rmw_phase_fsm #(.CNT_W(CNT_W), .IDLE_CLKS(IDLE_CLKS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_rd_cnt(req_rd_cnt), .req_wr_cnt(req_wr_cnt),
        .ta_i(ta_i), .mod_done(mod_done), .phase(phase),
        .req_ready(req_ready), .accept(accept), .last_wr(last_wr),
        .rd_hit(rd_hit), .seq_end(seq_end), .xfer_idx(xfer_idx)
    );

    rmw_lane_dec u_lanes (
        .size(size_q), .a_lo(base_q[1:0]), .drive(phase == PH_WDATA),
        .wdata(wr_data), .oe(data_oe), .dout(data_out)
    );

    // Request fields held for the whole sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            size_q <= '0;
        end else if (accept) begin
            base_q <= req_addr;
            size_q <= req_size;
        end
    end

    // Read capture and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            done_o   <= 1'b0;
        end else begin
            if (rd_hit) rd_data <= data_in;
            rd_valid <= rd_hit;
            done_o   <= seq_end;
        end
    end

    // Bus strobes decoded from the phase
    always_comb begin
        bus_addr = base_q + (ADDR_W'(xfer_idx) << 2);
        bus_size = size_q;
        ts_o     = (phase == PH_RADDR) || (phase == PH_WADDR);
        tip_o    = (phase != PH_FREE) && (phase != PH_GAP);
        rw_o     = !((phase == PH_WADDR) || (phase == PH_WDATA));
        lock_o   = (phase != PH_FREE);
        locke_o  = !rw_o && last_wr;
    end
endmodule

// File: rtl/rmw_seq_chk.sv
// Protocol checker for the locked read-modify-write sequencer, bound to the top.
module rmw_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ts_o,
    input logic       tip_o,
    input logic       rw_o,
    input logic       lock_o,
    input logic       locke_o,
    input logic       ta_i,
    input logic [3:0] data_oe
);
    assert_ts_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ts_o |=> !ts_o);

    assert_ts_in_tip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ts_o |-> tip_o && lock_o);

    assert_gap_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_o && !tip_o) |-> (rw_o && !ts_o && data_oe == 4'b0 && !locke_o));

    assert_locke_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        locke_o |-> (lock_o && !rw_o));

    assert_drive_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe != 4'b0) |-> (!rw_o && tip_o && !ts_o));

    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((data_oe != 4'b0) && ta_i) |=> (data_oe == 4'b0));

    assert_unlock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_o) |-> $past(locke_o));
endmodule

bind rmw_lock_seq rmw_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ts_o(ts_o), .tip_o(tip_o), .rw_o(rw_o),
    .lock_o(lock_o), .locke_o(locke_o), .ta_i(ta_i), .data_oe(data_oe)
);

// File: tb/sim_rmw_lock_seq.sv
`timescale 1ns/1ps
module sim_rmw_lock_seq;
    localparam int IDLE = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [2:0]  req_rd_cnt = 3'd1, req_wr_cnt = 3'd1;
    logic        mod_done = 1'b0;
    logic [31:0] wr_data = '0, rd_data, data_in = '0, data_out, bus_addr;
    logic        rd_valid, done_o, ts_o, tip_o, rw_o, lock_o, locke_o;
    logic        ta_i = 1'b0;
    logic [1:0]  bus_size;
    logic [3:0]  data_oe;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    bit pend_done = 0, pend_rd = 0;
    logic [31:0] pend_word = '0;
    logic [31:0] n_a;
    logic [1:0]  n_sz;
    int n_rd, n_wr;

    always #2 clk = ~clk;

    rmw_lock_seq #(.ADDR_W(32), .CNT_W(3), .IDLE_CLKS(IDLE)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_rd_cnt(req_rd_cnt),
        .req_wr_cnt(req_wr_cnt), .mod_done(mod_done), .wr_data(wr_data),
        .rd_data(rd_data), .rd_valid(rd_valid), .done_o(done_o),
        .bus_addr(bus_addr), .bus_size(bus_size), .ts_o(ts_o), .tip_o(tip_o),
        .rw_o(rw_o), .lock_o(lock_o), .locke_o(locke_o), .ta_i(ta_i),
        .data_in(data_in), .data_out(data_out), .data_oe(data_oe)
    );

    // Expected lane enables, from the size encoding in R7
    function automatic logic [3:0] exp_lanes(input logic [1:0] sz, input logic [1:0] a);
        if (sz == 2'b00) return 4'b0001 << a;
        if (sz == 2'b01) return a[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] lane_bits(input logic [3:0] m);
        return {{8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Registered side outputs that answer the previous clock
    task automatic chk_pending();
        chk({31'b0, done_o}, {31'b0, pend_done}, "R9 done");
        chk({31'b0, rd_valid}, {31'b0, pend_rd}, "R2 rd_valid");
        if (pend_rd) chk(rd_data, pend_word, "R2 rd_data");
        pend_done = 0;
        pend_rd = 0;
    endtask

    task automatic run_seq(input logic [31:0] a, input logic [1:0] sz, input int nr,
                           input int nw, input bit pre, input bit chain);
        logic [3:0]  m;
        logic [31:0] w;
        int extra;
        m = exp_lanes(sz, a[1:0]);
        if (!pre) begin
            req_valid = 1; req_addr = a; req_size = sz;
            req_rd_cnt = 3'(nr); req_wr_cnt = 3'(nw);
            #1;
            chk({31'b0, req_ready}, 32'd1, "R1 ready");
            chk({31'b0, lock_o}, 32'd0, "R1 lock before");
            chk_pending();
            step();
            req_valid = 0;
        end
        for (int r = 0; r < nr; r++) begin
            ta_i = 1'($urandom % 2); mod_done = 0;
            #1;
            chk({ts_o, tip_o, rw_o, lock_o, locke_o}, 32'b11110, "R2 read addr strobes");
            chk(bus_addr, a + 32'(4 * r), "R2 read address");
            chk({28'b0, data_oe}, 0, "R2 no drive");
            if (r == 0) chk({31'b0, lock_o}, 32'd1, "R1 lock set");
            if (r == 0 && pre) chk({31'b0, tip_o}, 32'd1, "R10 tip held");
            chk_pending();
            step();
            for (int k = $urandom % 3; k > 0; k--) begin
                ta_i = 0;
                #1;
                chk({ts_o, tip_o, rw_o}, 32'b011, "R3 read wait");
                chk_pending();
                step();
            end
            ta_i = 1; w = $urandom; data_in = w;
            #1;
            chk({ts_o, tip_o, rw_o}, 32'b011, "R2 read data clk");
            chk_pending();
            step();
            pend_rd = 1; pend_word = w;
        end
        extra = $urandom % 4;
        for (int g = 0; ; g++) begin
            ta_i = 1'($urandom % 2);
            mod_done = (g >= extra);
            #1;
            chk({ts_o, tip_o, rw_o, lock_o, locke_o}, 32'b00110, "R4 idle strobes");
            chk({28'b0, data_oe}, 0, "R4 idle undriven");
            chk_pending();
            step();
            if (g >= IDLE - 1 && g >= extra) break;
        end
        for (int k = 0; k < nw; k++) begin
            bit lastw;
            lastw = (k == nw - 1);
            wr_data = $urandom; ta_i = 1'($urandom % 2);
            #1;
            chk({ts_o, tip_o, rw_o, lock_o}, 32'b1101, "R5 write addr strobes");
            chk(bus_addr, a + 32'(4 * k), "R5 write address");
            chk({28'b0, data_oe}, 0, "R8 released / R5 undriven");
            chk({31'b0, locke_o}, {31'b0, lastw}, "R6 locke addr clk");
            chk_pending();
            step();
            for (int j = $urandom % 3; j > 0; j--) begin
                ta_i = 0;
                #1;
                chk({ts_o, tip_o, rw_o}, 32'b010, "R3 write wait");
                chk({31'b0, locke_o}, {31'b0, lastw}, "R6 locke wait");
                chk({28'b0, data_oe}, {28'b0, m}, "R7 lanes");
                chk_pending();
                step();
            end
            ta_i = 1;
            if (lastw && chain) begin
                req_valid = 1; req_addr = n_a; req_size = n_sz;
                req_rd_cnt = 3'(n_rd); req_wr_cnt = 3'(n_wr);
            end
            #1;
            chk({28'b0, data_oe}, {28'b0, m}, "R7 lanes");
            chk(data_out & lane_bits(m), wr_data & lane_bits(m), "R7 lane data");
            chk({31'b0, locke_o}, {31'b0, lastw}, "R6 locke data clk");
            if (lastw && chain) chk({31'b0, req_ready}, 32'd1, "R10 ready at end");
            chk_pending();
            step();
            req_valid = 0; ta_i = 0;
            if (lastw) pend_done = 1;
        end
        if (!chain) begin
            #1;
            chk({ts_o, tip_o, rw_o, lock_o, locke_o}, 32'b00100, "R9 released");
            chk({28'b0, data_oe}, 0, "R8 released");
            chk_pending();
            step();
        end
    endtask

    initial begin
        void'($urandom(32'd4177));
        @(negedge clk);
        #1;
        chk({ts_o, tip_o, rw_o, lock_o, locke_o}, 32'b00100, "R11 reset strobes");
        chk({28'b0, data_oe}, 0, "R11 reset undriven");
        step();
        rst_n = 1;
        step();
        // directed corners: byte at lane 3, halfword upper, several writes, late modify
        run_seq(32'h0000_1003, 2'b00, 1, 1, 0, 0);
        run_seq(32'h0000_2002, 2'b01, 2, 3, 0, 0);
        n_a = 32'h0000_3000; n_sz = 2'b10; n_rd = 1; n_wr = 2;
        run_seq(32'h0000_2f00, 2'b10, 1, 1, 0, 1);
        run_seq(32'h0000_3000, 2'b10, 1, 2, 1, 0);
        // random mix with occasional chaining
        begin
            logic [31:0] ca; logic [1:0] cs; int cr, cw; bit pre, ch;
            ca = $urandom; cs = 2'($urandom % 4); cr = 1 + $urandom % 3; cw = 1 + $urandom % 3;
            pre = 0;
            for (int i = 0; i < 30; i++) begin
                n_a = $urandom; n_sz = 2'($urandom % 4); n_rd = 1 + $urandom % 3; n_wr = 1 + $urandom % 3;
                ch = (i < 29) && ($urandom % 3 == 0);
                run_seq(ca, cs, cr, cw, pre, ch);
                pre = ch; ca = n_a; cs = n_sz; cr = n_rd; cw = n_wr;
            end
        end
        // reset in the middle of a write data clock
        req_valid = 1; req_addr = 32'h40; req_size = 2'b10; req_rd_cnt = 1; req_wr_cnt = 1;
        step(); req_valid = 0;
        step(); ta_i = 1; data_in = 32'h1; step(); ta_i = 0;
        mod_done = 1;
        repeat (IDLE + 2) step();
        chk({28'b0, data_oe}, 32'hf, "R7 before reset");
        rst_n = 0;
        step();
        #1;
        chk({ts_o, tip_o, rw_o, lock_o, locke_o}, 32'b00100, "R11 mid reset strobes");
        chk({28'b0, data_oe}, 0, "R11 mid reset undriven");
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule